// File: doc/BRIEF.md
# Power Mode Sequencer

This block decides which of three operating modes a system controller is in. The modes are full-speed run, low-speed run and frozen. It drives the qualifiers that the rest of the chip follows: a CPU clock enable, a flag that selects the slow clock, a CPU reset hold, and permission levels for the DMA engines and the output drivers. Software asks for a mode change by writing a two-bit mode code with a strobe. The hardware accepts the change only when the conditions for that mode are already met.

After reset the block is always in low-speed run, and software has to move it to full speed on purpose. Before it may drop back to low speed, every DMA channel must be off and every output driver must be released. The memory configuration bits must also be clear, except the lowest one. A request that breaks these rules is dropped and raises a sticky error flag.

A power-fail input that stays high long enough forces the frozen mode, whatever software is asking for. Frozen holds the CPU in reset with its clock stopped. A watchdog trap can also force the CPU reset on its own. A timekeeping tick runs without a break in every mode. The slow clock is not a second clock. It is a one-cycle enable pulse once every sixteen cycles, so the whole block stays in one clock domain.

Top module: `pwr_mode_seq`

## Requirements
- R1: After rst_ni is released, mode_o is 2'b01 (low-speed run), req_err_o is 0, cpu_rst_o is 0 while wdt_trap_i is 0, and dma_allow_o and port_allow_o are 0.
- R2: While mode_o is 2'b00 (full-speed run), cpu_clk_en_o is 1 on every cycle, cpu_slow_o is 0, and dma_allow_o and port_allow_o are 1.
- R3: While mode_o is 2'b01, cpu_slow_o is 1, dma_allow_o and port_allow_o are 0, and cpu_clk_en_o is high for exactly one cycle in every CLK_DIV cycles (default 16).
- R4: A strobe on req_valid_i with req_mode_i = 2'b00, taken in low-speed run, changes mode_o to 2'b00 on the next clock edge.
- R5: A strobe with req_mode_i = 2'b01, taken in full-speed run, changes mode_o to 2'b01 only when dma_en_i is all zero, port_oe_i is all zero, and mem_cfg_i is zero in every bit above bit 0. Bit 0 of mem_cfg_i has no effect on the decision.
- R6: A refused request for low-speed run leaves mode_o unchanged and sets req_err_o. req_err_o then stays 1 until reset.
- R7: A strobe with req_mode_i = 2'b10 enters frozen mode (mode_o 2'b10). In frozen mode cpu_rst_o is 1, cpu_clk_en_o is 0, and both allow outputs are 0. Only rst_ni leaves frozen mode; strobes have no effect there.
- R8: When pfail_i is 1 at PFAIL_DLY consecutive clock edges, mode_o is 2'b10 after the last of those edges, even if a strobe arrives at that edge. A high pulse that is shorter than this changes nothing.
- R9: wdt_trap_i = 1 drives cpu_rst_o to 1 in the same cycle, in any mode, and does not change mode_o.
- R10: tick_o pulses once every TICK_DIV cycles in every mode. Mode changes do not disturb its spacing.
- R11: A strobe with req_mode_i = 2'b11 changes nothing and does not set req_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 2 | Requested mode: 00 full, 01 low-speed, 10 frozen |
| dma_en_i | input | NUM_DMA | Enable bit of each DMA channel |
| port_oe_i | input | NUM_PORTS | Output-enable bit of each output port |
| mem_cfg_i | input | CFG_W | Memory configuration bits |
| pfail_i | input | 1 | Main power failure indication |
| wdt_trap_i | input | 1 | Watchdog trap |
| mode_o | output | 2 | Current mode code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| cpu_slow_o | output | 1 | Divided CPU clock selected |
| cpu_rst_o | output | 1 | CPU reset hold |
| dma_allow_o | output | 1 | DMA activity permitted |
| port_allow_o | output | 1 | Output drivers permitted |
| tick_o | output | 1 | Timekeeping tick |
| req_err_o | output | 1 | Sticky refused-request flag |

## Verification
A wrong mode register shows on mode_o and the qualifier outputs in the cycle right after the edge that corrupted it. A guard fault shows the first time software asks for low-speed run with a condition unmet. For that reason the bench sweeps every combination of the DMA, port and configuration inputs. A slip in either divider changes the spacing of cpu_clk_en_o or tick_o within one period, and the bench measures that spacing in each mode. A fault in the power-fail filter shows within PFAIL_DLY cycles, either as an early freeze or as a missed one.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    MODE_FULL   = 2'b00,
    MODE_SLOW   = 2'b01,
    MODE_FROZEN = 2'b10
  } pm_mode_e;
endpackage

// File: rtl/pms_pulse_div.sv
module pms_pulse_div #(
  parameter int PERIOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pulse_o
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_o = (cnt_q == LAST);
endmodule

// File: rtl/pms_pfail_filter.sv
module pms_pfail_filter #(
  parameter int DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pfail_i,
  output logic trip_o
);
  localparam int W = $clog2(DLY + 1);
  localparam logic [W-1:0] LAST = W'(DLY - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!pfail_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // trips on the DLY-th consecutive high sample
  assign trip_o = pfail_i && (cnt_q == LAST);
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
  import pms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_mode_i,
  input  logic       slow_ok_i,
  input  logic       trip_i,
  output pm_mode_e   mode_o,
  output logic       err_o
);
  pm_mode_e mode_q, mode_d;
  logic     refuse;
  logic     err_q;

  always_comb begin
    mode_d = mode_q;
    refuse = 1'b0;
    if (trip_i) begin
      mode_d = MODE_FROZEN;
    end else if (req_valid_i && mode_q != MODE_FROZEN) begin
      case (req_mode_i)
        2'b00: if (mode_q == MODE_SLOW) mode_d = MODE_FULL;
        2'b01: if (mode_q == MODE_FULL) begin
                 if (slow_ok_i) mode_d = MODE_SLOW;
                 else           refuse = 1'b1;
               end
        2'b10: mode_d = MODE_FROZEN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SLOW;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_q | refuse;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NUM_DMA   = 3,
  parameter int NUM_PORTS = 4,
  parameter int CFG_W     = 4,
  parameter int CLK_DIV   = 16,
  parameter int TICK_DIV  = 32768,
  parameter int PFAIL_DLY = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_mode_i,
  input  logic [NUM_DMA-1:0]   dma_en_i,
  input  logic [NUM_PORTS-1:0] port_oe_i,
  input  logic [CFG_W-1:0]     mem_cfg_i,
  input  logic                 pfail_i,
  input  logic                 wdt_trap_i,
  output logic [1:0]           mode_o,
  output logic                 cpu_clk_en_o,
  output logic                 cpu_slow_o,
  output logic                 cpu_rst_o,
  output logic                 dma_allow_o,
  output logic                 port_allow_o,
  output logic                 tick_o,
  output logic                 req_err_o
);
  // bit 0 of the memory configuration may stay set in low-speed run
  localparam logic [CFG_W-1:0] CFG_KEEP = CFG_W'(1);

  pm_mode_e mode;
  logic     slow_ok, trip, slow_pulse;

  assign slow_ok = (dma_en_i == '0) && (port_oe_i == '0) &&
                   ((mem_cfg_i & ~CFG_KEEP) == '0);

  pms_pulse_div #(.PERIOD(CLK_DIV)) u_clk_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_o(slow_pulse));

  pms_pulse_div #(.PERIOD(TICK_DIV)) u_tick_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_o(tick_o));

  pms_pfail_filter #(.DLY(PFAIL_DLY)) u_pfail (
    .clk_i(clk_i), .rst_ni(rst_ni), .pfail_i(pfail_i), .trip_o(trip));

  pms_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
    .req_mode_i(req_mode_i), .slow_ok_i(slow_ok), .trip_i(trip),
    .mode_o(mode), .err_o(req_err_o));

  always_comb begin
    case (mode)
      MODE_FULL:   cpu_clk_en_o = 1'b1;
      MODE_SLOW:   cpu_clk_en_o = slow_pulse;
      default:     cpu_clk_en_o = 1'b0;
    endcase
  end

  assign mode_o       = mode;
  assign cpu_slow_o   = (mode == MODE_SLOW);
  assign cpu_rst_o    = (mode == MODE_FROZEN) | wdt_trap_i;
  assign dma_allow_o  = (mode == MODE_FULL);
  assign port_allow_o = (mode == MODE_FULL);
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int NUM_DMA   = 3,
  parameter int NUM_PORTS = 4,
  parameter int CFG_W     = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_DMA-1:0]   dma_en_i,
  input logic [NUM_PORTS-1:0] port_oe_i,
  input logic [CFG_W-1:0]     mem_cfg_i,
  input logic                 wdt_trap_i,
  input logic [1:0]           mode_o,
  input logic                 cpu_clk_en_o,
  input logic                 cpu_rst_o,
  input logic                 req_err_o
);
  logic guard_ok;
  assign guard_ok = (dma_en_i == '0) && (port_oe_i == '0) && (mem_cfg_i[CFG_W-1:1] == '0);

  a_r2_full_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b00 |-> cpu_clk_en_o);

  a_r3_slow_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && $past(mode_o) == 2'b01 && cpu_clk_en_o) |-> !$past(cpu_clk_en_o));

  a_r5_guarded_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01 && $past(mode_o) == 2'b00) |-> $past(guard_ok));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |=> req_err_o);

  a_r7_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |=> mode_o == 2'b10);

  a_r7_frozen_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'b10 |-> (cpu_rst_o && !cpu_clk_en_o));

  a_r9_wdt_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_trap_i |-> cpu_rst_o);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.NUM_DMA(NUM_DMA), .NUM_PORTS(NUM_PORTS), .CFG_W(CFG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dma_en_i(dma_en_i), .port_oe_i(port_oe_i),
  .mem_cfg_i(mem_cfg_i), .wdt_trap_i(wdt_trap_i), .mode_o(mode_o),
  .cpu_clk_en_o(cpu_clk_en_o), .cpu_rst_o(cpu_rst_o), .req_err_o(req_err_o));

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;
  localparam int ND = 3, NP = 4, NC = 4, CDIV = 16, TDIV = 10, PDLY = 4;

  logic clk = 0, rst_ni = 0, req_valid = 0, pfail = 0, wdt = 0;
  logic [1:0] req_mode = 0;
  logic [ND-1:0] dma_en = 0;
  logic [NP-1:0] port_oe = 0;
  logic [NC-1:0] mem_cfg = 0;
  logic [1:0] mode;
  logic clk_en, slow, cpu_rst, dma_allow, port_allow, tick, err;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.NUM_DMA(ND), .NUM_PORTS(NP), .CFG_W(NC), .CLK_DIV(CDIV),
                 .TICK_DIV(TDIV), .PFAIL_DLY(PDLY)) u_pwr_mode_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .dma_en_i(dma_en), .port_oe_i(port_oe), .mem_cfg_i(mem_cfg), .pfail_i(pfail),
    .wdt_trap_i(wdt), .mode_o(mode), .cpu_clk_en_o(clk_en), .cpu_slow_o(slow),
    .cpu_rst_o(cpu_rst), .dma_allow_o(dma_allow), .port_allow_o(port_allow),
    .tick_o(tick), .req_err_o(err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; req_valid = 0; pfail = 0; wdt = 0;
    dma_en = 0; port_oe = 0; mem_cfg = 0;
    @(posedge clk); @(posedge clk); @(negedge clk); rst_ni = 1;
  endtask

  task automatic write(input logic [1:0] code);
    @(negedge clk); req_valid = 1; req_mode = code;
    @(posedge clk); @(negedge clk); req_valid = 0;
  endtask

  task automatic span(input bit use_tick, output int n);
    n = 0;
    do @(negedge clk); while (!(use_tick ? tick : clk_en));
    do begin @(negedge clk); n++; end while (!(use_tick ? tick : clk_en) && n < 100);
  endtask

  int n;
  bit allowed;

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 mode", mode, 1); chk("R1 err", err, 0); chk("R1 rst", cpu_rst, 0);
    chk("R1 dma", dma_allow, 0); chk("R1 port", port_allow, 0);
    // R3 slow-run outputs and enable spacing
    chk("R3 slow", slow, 1);
    for (int i = 0; i < 3; i++) begin span(0, n); chk("R3 spacing", n, CDIV); end
    span(1, n); chk("R10 tick slow", n, TDIV);
    // R11 reserved code
    write(2'b11); chk("R11 mode", mode, 1); chk("R11 err", err, 0);
    // R4 go full speed
    write(2'b00); chk("R4 mode", mode, 0);
    // R2 full-speed outputs
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); chk("R2 clk_en", clk_en, 1);
    end
    chk("R2 slow", slow, 0); chk("R2 dma", dma_allow, 1); chk("R2 port", port_allow, 1);
    span(1, n); chk("R10 tick full", n, TDIV);
    // R9 watchdog
    @(negedge clk); wdt = 1; #1; chk("R9 rst", cpu_rst, 1);
    @(negedge clk); chk("R9 mode", mode, 0); wdt = 0; #1; chk("R9 release", cpu_rst, 0);
    // R8 short pulses are filtered
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); pfail = 1;
      repeat (PDLY - 1) @(negedge clk);
      pfail = 0;
      @(negedge clk); chk("R8 short pulse", mode, 0);
    end
    // R8 full-length pulse overrides a simultaneous request
    do_reset();
    @(negedge clk); pfail = 1;
    repeat (PDLY - 1) @(negedge clk);
    chk("R8 not yet", mode, 1);
    req_valid = 1; req_mode = 2'b00;
    @(negedge clk); req_valid = 0;
    chk("R8 freeze", mode, 2);
    pfail = 0;
    // R7 frozen outputs, no exit by write, tick continues
    chk("R7 rst", cpu_rst, 1); chk("R7 dma", dma_allow, 0); chk("R7 port", port_allow, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); chk("R7 clk_en", clk_en, 0);
    end
    write(2'b00); chk("R7 stays", mode, 2);
    write(2'b01); chk("R7 stays", mode, 2);
    span(1, n); chk("R10 tick frozen", n, TDIV);
    // R7 software freeze from full speed
    do_reset(); write(2'b00); write(2'b10); chk("R7 sw freeze", mode, 2);
    do_reset(); chk("R7 reset exit", mode, 1);
    // R5/R6 exhaustive guard sweep
    for (int v = 0; v < (1 << (ND + NP + NC)); v++) begin
      do_reset(); write(2'b00);
      @(negedge clk);
      {dma_en, port_oe, mem_cfg} = v[ND+NP+NC-1:0];
      allowed = (dma_en == 0) && (port_oe == 0) && (mem_cfg[NC-1:1] == 0);
      write(2'b01);
      chk("R5 guard", mode, allowed ? 1 : 0);
      chk("R6 err", err, allowed ? 0 : 1);
      if (!allowed) begin
        dma_en = 0; port_oe = 0; mem_cfg = 0;
        write(2'b01); chk("R6 sticky", err, 1);
        chk("R5 retry", mode, 1);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule